// File: doc/BRIEF.md
# Dual-Bank Row Cache Tracker

This block follows the state of a two-bank DRAM that keeps a full-row SRAM register in front of each bank. For every accepted command it decides whether the row was already cached, whether the bank must open a new row in its sense amplifiers, and whether the row register is reloaded. It keeps three pieces of state per bank: the open sense-amplifier row, a separate cached row tag, and a pending auto-precharge flag. A scaled data store (array plus row register) is kept so that coherency between cache and array can be seen on the read data.

A command is sampled on a rising clock edge when `cmd_valid_i` is high. Its response flags are registered and hold for the one cycle after that edge. They are all low when no command was taken. A mode-set command chooses how writes treat the row register and how many clocks a read takes to return data.

Top module: `row_cache_tracker`

## Requirements
- R1: Command codes are NOP=0, MODE=1, READ=2, READ with auto-precharge=3, WRITE=4, PRECHARGE=5. After reset all flags are low. Both banks are closed and their tags are invalid, so the first read to each bank reports miss, activate and load, and returns 0 from the zeroed array.
- R2: A READ (2 or 3) whose row differs from the bank's cached tag reports miss_o and load_o. It returns the array word at that row and column. It raises act_o only if that row is not already open in the bank.
- R3: A READ whose row equals the cached tag reports hit_o with act_o and load_o low, returns the row-register word, and never reports hit_o and miss_o together.
- R4: A MODE command (code 1) takes row bit 0 as write-transfer enable and row bit 1 as the high-clock-rate latency select. It ignores the bank and column, raises no flag, and leaves both banks' state untouched. Both bits are 0 after reset.
- R5: Read latency is one clock when row bit 1 of the last MODE was 0, and two clocks when it was 1. lat_o gives that value (1 or 2) for reads and 0 otherwise. rvalid_o and rdata_o appear in the cycle after the command edge for latency 1, and one cycle later for latency 2.
- R6: With write transfer on, every WRITE reports load_o. The cached tag becomes the written row, and its register holds that row with the new word merged in.
- R7: With write transfer off, a WRITE to a row other than the tag leaves the tag and register unchanged and reports miss_o without load_o. Later reads of the cached row still hit with the old data.
- R8: With write transfer off, a WRITE whose row equals the tag reports hit_o and also updates the row register, so a following read hit returns the written word.
- R9: A WRITE raises act_o exactly when the bank has no open row or a different open row. The written row is open afterwards.
- R10: PRECHARGE (code 5) closes the open row, raises no flag and keeps the tag valid. A later read of the cached row hits without activation, and a write to it activates.
- R11: READ with auto-precharge closes the bank one clock after the command. A read hit in the next cycle is served from the register without act_o, and a write to the same row afterwards raises act_o.
- R12: Commands to one bank do not change the other bank's tag, register or open row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Command code (R1) |
| cmd_bank_i | input | BANK_W | Bank select |
| cmd_row_i | input | ROW_W | Row address; mode bits for MODE |
| cmd_col_i | input | COL_W | Column within the row |
| cmd_wdata_i | input | DATA_W | Write data |
| hit_o | output | 1 | Row matched the cached tag |
| miss_o | output | 1 | Row did not match the cached tag |
| act_o | output | 1 | Bank activated a new row |
| load_o | output | 1 | Row register reloaded |
| lat_o | output | 2 | Read latency in clocks, 0 for non-reads |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | DATA_W | Read data |

## Verification
The bench aims at the places where the tag and the open row part ways. After a write with transfer off to an uncached row, a read of the written row must load without activating. A design that tied the tag to the open row would report a hit or a spurious activation there. A tag-matching write in that mode must update the register, or the next read returns stale data. After precharge or auto-precharge the tag must stay valid while the row is closed. A design that cleared the tag would miss, and one that kept the row open would skip the activation on the next write. Latency-two reads check that data does not show up a cycle early. A bank-1 sequence followed by a bank-0 hit catches crossed state.

// File: rtl/rct_pkg.sv
package rct_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_MRS  = 3'd1,
    OP_RD   = 3'd2,
    OP_RDAP = 3'd3,
    OP_WR   = 3'd4,
    OP_PRE  = 3'd5
  } op_e;

  typedef struct packed {
    logic hit;
    logic miss;
    logic act;
    logic load;
  } resp_t;
endpackage

// File: rtl/rct_bank.sv
module rct_bank
  import rct_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  op_e               op_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wt_mode_i,
  output resp_t             resp_o,
  output logic [DATA_W-1:0] rword_o
);
  localparam int ROWS = 1 << ROW_W;
  localparam int COLS = 1 << COL_W;

  logic              sa_open_q, ap_pend_q, tag_vld_q;
  logic [ROW_W-1:0]  sa_row_q, tag_row_q;
  logic [DATA_W-1:0] mem_q   [ROWS][COLS];
  logic [DATA_W-1:0] cache_q [COLS];

  logic is_rd, is_wr, sa_eff, tag_hit, sa_hit;
  resp_t resp;

  always_comb begin
    is_rd   = (op_i == OP_RD) || (op_i == OP_RDAP);
    is_wr   = (op_i == OP_WR);
    // a pending auto-precharge already counts as closed
    sa_eff  = sa_open_q && !ap_pend_q;
    tag_hit = tag_vld_q && (tag_row_q == row_i);
    sa_hit  = sa_eff && (sa_row_q == row_i);
    resp.hit  = sel_i && (is_rd || is_wr) && tag_hit;
    resp.miss = sel_i && (is_rd || is_wr) && !tag_hit;
    resp.act  = sel_i && ((is_rd && !tag_hit) || is_wr) && !sa_hit;
    resp.load = sel_i && ((is_rd && !tag_hit) || (is_wr && wt_mode_i));
    rword_o   = tag_hit ? cache_q[col_i] : mem_q[row_i][col_i];
    resp_o    = resp;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sa_open_q <= 1'b0;
      sa_row_q  <= '0;
      ap_pend_q <= 1'b0;
      tag_vld_q <= 1'b0;
      tag_row_q <= '0;
    end else begin
      if (ap_pend_q) begin
        sa_open_q <= 1'b0;
        ap_pend_q <= 1'b0;
      end
      if (resp.act) begin
        sa_open_q <= 1'b1;
        sa_row_q  <= row_i;
      end
      if (sel_i && op_i == OP_PRE) begin
        sa_open_q <= 1'b0;
        ap_pend_q <= 1'b0;
      end
      if (sel_i && op_i == OP_RDAP) ap_pend_q <= 1'b1;
      if (resp.load) begin
        tag_vld_q <= 1'b1;
        tag_row_q <= row_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) mem_q[r][c] <= '0;
      for (int c = 0; c < COLS; c++) cache_q[c] <= '0;
    end else begin
      if (sel_i && is_wr) mem_q[row_i][col_i] <= wdata_i;
      if (resp.load) begin
        for (int c = 0; c < COLS; c++)
          cache_q[c] <= (is_wr && COL_W'(c) == col_i) ? wdata_i : mem_q[row_i][c];
      end else if (resp.hit && is_wr) begin
        cache_q[col_i] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/rct_rdpipe.sv
module rct_rdpipe #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              cl2_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              s1_v, s1_cl2, s2_v;
  logic [DATA_W-1:0] s1_d, s2_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v   <= 1'b0;
      s1_cl2 <= 1'b0;
      s1_d   <= '0;
      s2_v   <= 1'b0;
      s2_d   <= '0;
    end else begin
      s1_v   <= rd_i;
      s1_cl2 <= cl2_i;
      s1_d   <= data_i;
      s2_v   <= s1_v && s1_cl2;
      s2_d   <= s1_d;
    end
  end

  // each read carries the latency in force when it was issued
  assign rvalid_o = s2_v || (s1_v && !s1_cl2);
  assign rdata_o  = s2_v ? s2_d : s1_d;
endmodule

// File: rtl/row_cache_tracker.sv
module row_cache_tracker
  import rct_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  parameter int ROW_W     = 3,   // >= 2, mode bits ride on the row field
  parameter int COL_W     = 2,
  parameter int DATA_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [BANK_W-1:0] cmd_bank_i,
  input  logic [ROW_W-1:0]  cmd_row_i,
  input  logic [COL_W-1:0]  cmd_col_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic              act_o,
  output logic              load_o,
  output logic [1:0]        lat_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  op_e               op;
  logic              wt_q, cl2_q, is_rd;
  logic              sel   [NUM_BANKS];
  resp_t             resp  [NUM_BANKS];
  logic [DATA_W-1:0] rword [NUM_BANKS];
  resp_t             resp_any;
  logic [DATA_W-1:0] word;

  assign op    = op_e'(cmd_op_i);
  assign is_rd = cmd_valid_i && (op == OP_RD || op == OP_RDAP);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign sel[b] = cmd_valid_i && (cmd_bank_i == BANK_W'(b));
    rct_bank #(
      .ROW_W (ROW_W),
      .COL_W (COL_W),
      .DATA_W(DATA_W)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sel_i    (sel[b]),
      .op_i     (op),
      .row_i    (cmd_row_i),
      .col_i    (cmd_col_i),
      .wdata_i  (cmd_wdata_i),
      .wt_mode_i(wt_q),
      .resp_o   (resp[b]),
      .rword_o  (rword[b])
    );
  end

  always_comb begin
    resp_any = '0;
    word     = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      resp_any = resp_any | resp[b];
      if (sel[b]) word = rword[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wt_q   <= 1'b0;
      cl2_q  <= 1'b0;
      hit_o  <= 1'b0;
      miss_o <= 1'b0;
      act_o  <= 1'b0;
      load_o <= 1'b0;
      lat_o  <= 2'd0;
    end else begin
      if (cmd_valid_i && op == OP_MRS) begin
        wt_q  <= cmd_row_i[0];
        cl2_q <= cmd_row_i[1];
      end
      hit_o  <= resp_any.hit;
      miss_o <= resp_any.miss;
      act_o  <= resp_any.act;
      load_o <= resp_any.load;
      lat_o  <= is_rd ? (cl2_q ? 2'd2 : 2'd1) : 2'd0;
    end
  end

  rct_rdpipe #(.DATA_W(DATA_W)) u_rdpipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (is_rd),
    .cl2_i   (cl2_q),
    .data_i  (word),
    .rvalid_o(rvalid_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/rct_checker.sv
module rct_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic [2:0] cmd_op_i,
  input logic       hit_o,
  input logic       miss_o,
  input logic       act_o,
  input logic       load_o,
  input logic [1:0] lat_o,
  input logic       rvalid_o
);
  assert_hit_miss_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o));

  assert_rd_miss_loads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_o && lat_o != 2'd0) |-> load_o);

  assert_rd_hit_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && lat_o != 2'd0) |-> (!act_o && !load_o));

  assert_cl1_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_o == 2'd1) |-> rvalid_o);

  assert_cl2_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_o == 2'd2) |=> rvalid_o);

  assert_mode_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd1) |=> (!hit_o && !miss_o && !act_o && !load_o));

  assert_pre_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd5) |=> (!hit_o && !miss_o && lat_o == 2'd0));
endmodule

bind row_cache_tracker rct_checker u_rct_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_op_i   (cmd_op_i),
  .hit_o      (hit_o),
  .miss_o     (miss_o),
  .act_o      (act_o),
  .load_o     (load_o),
  .lat_o      (lat_o),
  .rvalid_o   (rvalid_o)
);

// File: tb/tb_row_cache_tracker.sv
`timescale 1ns/1ps
module tb_row_cache_tracker;
  localparam logic [2:0] C_MRS = 3'd1, C_RD = 3'd2, C_RDAP = 3'd3,
                         C_WR = 3'd4, C_PRE = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [0:0] cmd_bank = '0;
  logic [2:0] cmd_row = '0;
  logic [1:0] cmd_col = '0;
  logic [7:0] cmd_wdata = '0;
  logic       hit, miss, act, load, rvalid;
  logic [1:0] lat;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic       r_hit, r_miss, r_act, r_load, r_rv, r_rv2;
  logic [1:0] r_lat;
  logic [7:0] r_rd, r_rd2;

  always #4 clk = ~clk;

  row_cache_tracker dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_bank_i(cmd_bank), .cmd_row_i(cmd_row), .cmd_col_i(cmd_col),
    .cmd_wdata_i(cmd_wdata), .hit_o(hit), .miss_o(miss), .act_o(act),
    .load_o(load), .lat_o(lat), .rvalid_o(rvalid), .rdata_o(rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int actv, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, actv, expv);
    end
  endtask

  task automatic issue(input logic [2:0] op, input int bank, input int row,
                       input int col, input int wd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bank = bank[0:0];
    cmd_row = row[2:0]; cmd_col = col[1:0]; cmd_wdata = wd[7:0];
    @(posedge clk); #1;
    r_hit = hit; r_miss = miss; r_act = act; r_load = load;
    r_lat = lat; r_rv = rvalid; r_rd = rdata;
    cmd_valid = 1'b0;
    r_rv2 = 1'b0; r_rd2 = '0;
    if (r_lat == 2'd2) begin
      @(posedge clk); #1;
      r_rv2 = rvalid; r_rd2 = rdata;
    end
  endtask

  task automatic flags(input string req, input bit h, input bit m, input bit a, input bit l);
    chk(r_hit == h,  req, "hit",  r_hit,  h);
    chk(r_miss == m, req, "miss", r_miss, m);
    chk(r_act == a,  req, "act",  r_act,  a);
    chk(r_load == l, req, "load", r_load, l);
  endtask

  task automatic rd_expect(input string req, input int cl, input int data);
    chk(r_lat == 2'(cl), req, "lat", r_lat, cl);
    if (cl == 1) begin
      chk(r_rv == 1'b1, req, "rvalid", r_rv, 1);
      chk(r_rd == 8'(data), req, "rdata", r_rd, data);
    end else begin
      chk(r_rv == 1'b0, req, "early rvalid", r_rv, 0);
      chk(r_rv2 == 1'b1, req, "rvalid", r_rv2, 1);
      chk(r_rd2 == 8'(data), req, "rdata", r_rd2, data);
    end
  endtask

  task automatic t_reset();
    chk({hit, miss, act, load, rvalid} == 5'b0 && lat == 2'd0, "R1", "reset flags",
        {hit, miss, act, load, rvalid}, 0);
  endtask

  task automatic t_read_miss_hit();
    issue(C_RD, 0, 2, 1, 0);
    flags("R1", 0, 1, 1, 1); rd_expect("R2", 1, 8'h00);
    issue(C_RD, 0, 2, 3, 0);
    flags("R3", 1, 0, 0, 0); rd_expect("R3", 1, 8'h00);
  endtask

  task automatic t_no_transfer();
    issue(C_WR, 0, 5, 0, 8'hA5);
    flags("R7", 0, 1, 1, 0);
    chk(r_lat == 2'd0, "R5", "write lat", r_lat, 0);
    issue(C_WR, 0, 5, 1, 8'h3C);
    flags("R9", 0, 1, 0, 0);
    issue(C_RD, 0, 2, 0, 0);
    flags("R7", 1, 0, 0, 0); rd_expect("R7", 1, 8'h00);
    issue(C_RD, 0, 5, 0, 0);
    flags("R2", 0, 1, 0, 1); rd_expect("R2", 1, 8'hA5);
    issue(C_WR, 0, 5, 1, 8'h77);
    flags("R8", 1, 0, 0, 0);
    issue(C_RD, 0, 5, 1, 0);
    flags("R8", 1, 0, 0, 0); rd_expect("R8", 1, 8'h77);
  endtask

  task automatic t_transfer();
    issue(C_MRS, 1, 1, 3, 8'hFF);
    flags("R4", 0, 0, 0, 0);
    chk(r_lat == 2'd0, "R4", "mode lat", r_lat, 0);
    issue(C_WR, 0, 6, 2, 8'h5E);
    flags("R6", 0, 1, 1, 1);
    issue(C_RD, 0, 6, 2, 0);
    flags("R6", 1, 0, 0, 0); rd_expect("R6", 1, 8'h5E);
    issue(C_RD, 0, 5, 1, 0);
    flags("R2", 0, 1, 1, 1); rd_expect("R2", 1, 8'h77);
  endtask

  task automatic t_latency2();
    issue(C_MRS, 0, 2, 0, 0);
    flags("R4", 0, 0, 0, 0);
    issue(C_RD, 0, 5, 1, 0);
    flags("R5", 1, 0, 0, 0); rd_expect("R5", 2, 8'h77);
    issue(C_MRS, 0, 0, 0, 0);
    issue(C_RD, 0, 5, 1, 0);
    rd_expect("R5", 1, 8'h77);
  endtask

  task automatic t_precharge();
    issue(C_PRE, 0, 0, 0, 0);
    flags("R10", 0, 0, 0, 0);
    issue(C_RD, 0, 5, 0, 0);
    flags("R10", 1, 0, 0, 0); rd_expect("R10", 1, 8'hA5);
    issue(C_WR, 0, 5, 2, 8'h11);
    flags("R10", 1, 0, 1, 0);
  endtask

  task automatic t_auto_pre();
    issue(C_RDAP, 1, 3, 0, 0);
    flags("R1", 0, 1, 1, 1); rd_expect("R1", 1, 8'h00);
    issue(C_RD, 1, 3, 1, 0);
    flags("R11", 1, 0, 0, 0); rd_expect("R11", 1, 8'h00);
    issue(C_WR, 1, 3, 1, 8'h42);
    flags("R11", 1, 0, 1, 0);
    issue(C_WR, 1, 3, 2, 8'h43);
    flags("R9", 1, 0, 0, 0);
    issue(C_RD, 1, 3, 1, 0);
    rd_expect("R8", 1, 8'h42);
  endtask

  task automatic t_banks();
    issue(C_RD, 0, 5, 2, 0);
    flags("R12", 1, 0, 0, 0); rd_expect("R12", 1, 8'h11);
    issue(C_WR, 0, 5, 3, 8'h99);
    flags("R12", 1, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 t_reset();
    t_read_miss_hit();
    t_no_transfer();
    t_transfer();
    t_latency2();
    t_precharge();
    t_auto_pre();
    t_banks();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule